// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block chooses which pending interrupt a small CPU core takes next. Each of `N` maskable sources has a request line, an enable bit and a one-bit priority level. Next to these sources are a non-maskable interrupt line and an address-break line. The arbiter looks at its inputs only on a clock edge where the CPU reports an instruction boundary. If a source is eligible at that edge, the next cycle holds a one-cycle acceptance pulse. That pulse carries the vector address of the winner, a set-mask request to the CPU, and an acknowledge for exactly one source.

Maskable sources are ordered first by their level bit and then by index. A level-1 source beats any level-0 source, and a lower index wins within a level. The CPU's global mask bit holds every maskable source pending. NMI and address break ignore the mask and the level bits: NMI is always first and address break is second. The arbiter works only when the two mode-select inputs are both 0. Any other mode code stops it from accepting anything.

Top module: `intc_two_level`

## Requirements
- R1: A maskable source whose enable bit is 0 is never accepted, whatever its request line shows.
- R2: Acceptance happens only when `boundary_i` is 1 at a rising clock edge. `irq_o`, `set_mask_o` and the acknowledge outputs go high for exactly the one cycle after that edge, and they stay 0 after any edge where `boundary_i` is 0.
- R3: NMI wins over everything and address break wins over every maskable source. Neither is held back by `mask_i` or by any level bit.
- R4: While `mask_i` is 1, no maskable source is accepted.
- R5: An enabled, requesting source with level bit 1 is accepted ahead of every source with level bit 0.
- R6: Among eligible sources of equal level, the lowest index wins.
- R7: `vector_o` is `NMI_VEC` for NMI, `BRK_VEC` for address break, and `SRC_BASE + 4*i` for maskable source `i`. It is valid while `irq_o` is 1.
- R8: `set_mask_o` is 1 in every acceptance cycle. A boundary edge that falls within an acceptance cycle accepts nothing.
- R9: In an acceptance cycle exactly one of `ack_o[N-1:0]`, `nmi_ack_o` and `brk_ack_o` is 1, and it names the winner. All of them are 0 in every other cycle.
- R10: When `mode_i` is not 2'b00, nothing is accepted, including NMI.
- R11: During and right after reset, `irq_o`, `set_mask_o` and all acknowledge outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Level-held request of each maskable source |
| en_i | input | N | Per-source enable |
| lvl_i | input | N | Per-source priority level (1 = high) |
| nmi_i | input | 1 | Non-maskable interrupt request |
| brk_i | input | 1 | Address-break request |
| mask_i | input | 1 | CPU global mask bit |
| boundary_i | input | 1 | Instruction-boundary strobe |
| mode_i | input | 2 | Control mode; only 2'b00 enables arbitration |
| irq_o | output | 1 | Interrupt accepted, one-cycle pulse |
| set_mask_o | output | 1 | Request to set the CPU mask bit |
| vector_o | output | VW | Vector address of the accepted request |
| ack_o | output | N | One-hot acknowledge to the accepted maskable source |
| nmi_ack_o | output | 1 | Acknowledge to NMI |
| brk_ack_o | output | 1 | Acknowledge to address break |

## Verification
The bench sets a high-index level-1 source against a low-index level-0 source. A design that ignored the level bit would pick the low index. It sets two sources of the same level against each other, where a reversed scan would pick the wrong one. It asserts the mask together with NMI or address break, which a design that masks too broadly would drop. It also sends a boundary strobe in the acceptance cycle itself. A design that did not apply the mask at once would accept the still-held request a second time. Disabled sources that are requesting, non-zero mode codes and edges without a strobe must all produce silence. Several thousand random cycles are compared against a reference function of the same rules.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_NMI  = 2'd1,
      WIN_BRK  = 2'd2,
      WIN_SRC  = 2'd3
   } win_kind_e;
endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  vec_i,
   output logic          hit_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      hit_o = |vec_i;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/intc_select.sv
module intc_select
   import intc_pkg::*;
#(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  pend_i,
   input  logic [N-1:0]  lvl_i,
   input  logic          nmi_i,
   input  logic          brk_i,
   input  logic          mask_i,
   output win_kind_e     kind_o,
   output logic [IW-1:0] idx_o
);
   logic [N-1:0]  hi_vec, lo_vec;
   logic          hi_hit, lo_hit;
   logic [IW-1:0] hi_idx, lo_idx;

   assign hi_vec = pend_i & lvl_i;
   assign lo_vec = pend_i & ~lvl_i;

   intc_first_set #(.W(N), .IW(IW)) i_hi (.vec_i(hi_vec), .hit_o(hi_hit), .idx_o(hi_idx));
   intc_first_set #(.W(N), .IW(IW)) i_lo (.vec_i(lo_vec), .hit_o(lo_hit), .idx_o(lo_idx));

   always_comb begin
      kind_o = WIN_NONE;
      idx_o  = '0;
      if (nmi_i) begin
         kind_o = WIN_NMI;
      end else if (brk_i) begin
         kind_o = WIN_BRK;
      end else if (!mask_i && hi_hit) begin
         kind_o = WIN_SRC;
         idx_o  = hi_idx;
      end else if (!mask_i && lo_hit) begin
         kind_o = WIN_SRC;
         idx_o  = lo_idx;
      end
   end
endmodule

// File: rtl/intc_vector.sv
module intc_vector
   import intc_pkg::*;
#(
   parameter int          IW       = 3,
   parameter int          VW       = 16,
   parameter int unsigned NMI_VEC  = 32'h1C,
   parameter int unsigned BRK_VEC  = 32'h20,
   parameter int unsigned SRC_BASE = 32'h40
) (
   input  win_kind_e     kind_i,
   input  logic [IW-1:0] idx_i,
   output logic [VW-1:0] vec_o
);
   always_comb begin
      unique case (kind_i)
         WIN_NMI: vec_o = VW'(NMI_VEC);
         WIN_BRK: vec_o = VW'(BRK_VEC);
         WIN_SRC: vec_o = VW'(SRC_BASE) + (VW'(idx_i) << 2);
         default: vec_o = '0;
      endcase
   end
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level
   import intc_pkg::*;
#(
   parameter int          N        = 8,
   parameter int          VW       = 16,
   parameter int unsigned NMI_VEC  = 32'h1C,
   parameter int unsigned BRK_VEC  = 32'h20,
   parameter int unsigned SRC_BASE = 32'h40
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  req_i,
   input  logic [N-1:0]  en_i,
   input  logic [N-1:0]  lvl_i,
   input  logic          nmi_i,
   input  logic          brk_i,
   input  logic          mask_i,
   input  logic          boundary_i,
   input  logic [1:0]    mode_i,
   output logic          irq_o,
   output logic          set_mask_o,
   output logic [VW-1:0] vector_o,
   output logic [N-1:0]  ack_o,
   output logic          nmi_ack_o,
   output logic          brk_ack_o
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;
   localparam longint TOP_VEC = longint'(SRC_BASE) + 64'(4 * (N - 1));

   if (N < 1 || N > 64) begin : g_bad_n
      $error("intc_two_level: N must lie in 1..64");
   end
   if (VW < 2 || VW > 32) begin : g_bad_vw
      $error("intc_two_level: VW must lie in 2..32");
   end
   if (TOP_VEC >= (64'd1 << VW) || longint'(NMI_VEC) >= (64'd1 << VW)
       || longint'(BRK_VEC) >= (64'd1 << VW)) begin : g_bad_vec
      $error("intc_two_level: vector addresses do not fit in VW bits");
   end

   logic [N-1:0]  pend;
   logic [N-1:0]  ack_d;
   win_kind_e     kind;
   logic [IW-1:0] idx;
   logic [VW-1:0] vec_d;
   logic          accept;
   logic          irq_q;
   logic [VW-1:0] vec_q;
   logic [N-1:0]  ack_q;
   logic          nmi_q, brk_q;

   for (genvar i = 0; i < N; i++) begin : g_src
      assign pend[i]  = req_i[i] & en_i[i];
      assign ack_d[i] = accept && (kind == WIN_SRC) && (idx == IW'(i));
   end

   intc_select #(.N(N), .IW(IW)) i_select (
      .pend_i (pend),
      .lvl_i  (lvl_i),
      .nmi_i  (nmi_i),
      .brk_i  (brk_i),
      .mask_i (mask_i),
      .kind_o (kind),
      .idx_o  (idx)
   );

   intc_vector #(
      .IW(IW), .VW(VW), .NMI_VEC(NMI_VEC), .BRK_VEC(BRK_VEC), .SRC_BASE(SRC_BASE)
   ) i_vector (
      .kind_i (kind),
      .idx_i  (idx),
      .vec_o  (vec_d)
   );

   // irq_q stands for the mask bit that the CPU sets at the end of this cycle.
   assign accept = boundary_i && (mode_i == 2'b00) && !irq_q && (kind != WIN_NONE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
         vec_q <= '0;
         ack_q <= '0;
         nmi_q <= 1'b0;
         brk_q <= 1'b0;
      end else begin
         irq_q <= accept;
         ack_q <= ack_d;
         nmi_q <= accept && (kind == WIN_NMI);
         brk_q <= accept && (kind == WIN_BRK);
         if (accept) vec_q <= vec_d;
      end
   end

   assign irq_o      = irq_q;
   assign set_mask_o = irq_q;
   assign vector_o   = vec_q;
   assign ack_o      = ack_q;
   assign nmi_ack_o  = nmi_q;
   assign brk_ack_o  = brk_q;
endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
   parameter int          N        = 8,
   parameter int          VW       = 16,
   parameter int unsigned NMI_VEC  = 32'h1C,
   parameter int unsigned BRK_VEC  = 32'h20,
   parameter int unsigned SRC_BASE = 32'h40
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [N-1:0]  req_i,
   input logic [N-1:0]  en_i,
   input logic [N-1:0]  lvl_i,
   input logic          nmi_i,
   input logic          brk_i,
   input logic          mask_i,
   input logic          boundary_i,
   input logic [1:0]    mode_i,
   input logic          irq_o,
   input logic          set_mask_o,
   input logic [VW-1:0] vector_o,
   input logic [N-1:0]  ack_o,
   input logic          nmi_ack_o,
   input logic          brk_ack_o
);
   assert_irq_at_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> $past(boundary_i));

   assert_setmask_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_mask_o |-> $past(boundary_i));

   assert_no_back_to_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   assert_single_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ($countones({ack_o, nmi_ack_o, brk_ack_o}) == 1));

   assert_ack_needs_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ack_o, nmi_ack_o, brk_ack_o}) && (!irq_o -> ({ack_o, nmi_ack_o, brk_ack_o} == '0)));

   assert_nmi_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boundary_i && nmi_i && mode_i == 2'b00 && !irq_o) |=> nmi_ack_o);

   assert_nmi_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_ack_o |-> (vector_o == VW'(NMI_VEC)));

   assert_brk_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_ack_o |-> (vector_o == VW'(BRK_VEC)));

   assert_masked_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|ack_o) |-> $past(!mask_i));

   assert_mode_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> ($past(mode_i) == 2'b00));

   for (genvar i = 0; i < N; i++) begin : g_src_chk
      localparam logic [N-1:0] LOWER = N'((64'd1 << i) - 64'd1);

      assert_enabled_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_o[i] |-> $past(req_i[i] && en_i[i]));

      assert_level_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_o[i] |-> $past(lvl_i[i] || ((req_i & en_i & lvl_i) == '0)));

      assert_low_index_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_o[i] |-> $past((req_i & en_i & ~(lvl_i ^ {N{lvl_i[i]}}) & LOWER) == '0));

      assert_src_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ack_o[i] |-> (vector_o == VW'(SRC_BASE + 4 * i)));
   end

   always_comb begin
      if (!rst_ni) begin
         assert_reset_quiet_R11: assert (!irq_o && !set_mask_o && ack_o == '0);
      end
   end
endmodule

bind intc_two_level intc_two_level_chk #(
   .N(N), .VW(VW), .NMI_VEC(NMI_VEC), .BRK_VEC(BRK_VEC), .SRC_BASE(SRC_BASE)
) i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .en_i(en_i), .lvl_i(lvl_i),
   .nmi_i(nmi_i), .brk_i(brk_i), .mask_i(mask_i), .boundary_i(boundary_i),
   .mode_i(mode_i), .irq_o(irq_o), .set_mask_o(set_mask_o), .vector_o(vector_o),
   .ack_o(ack_o), .nmi_ack_o(nmi_ack_o), .brk_ack_o(brk_ack_o)
);

// File: tb/test_intc_two_level.sv
module test_intc_two_level;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int VW = 16;
   localparam logic [VW-1:0] NMI_V = 16'h001C;
   localparam logic [VW-1:0] BRK_V = 16'h0020;
   localparam logic [VW-1:0] SRC_V = 16'h0040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0, en = '0, lvl = '0;
   logic          nmi = 1'b0, brk = 1'b0, mask = 1'b0, bnd = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic          irq, set_mask, nmi_ack, brk_ack;
   logic [VW-1:0] vector;
   logic [N-1:0]  ack;

   int checks = 0;
   int fails  = 0;
   logic          prev_irq = 1'b0;
   logic          e_irq, e_nmi, e_brk;
   logic [VW-1:0] e_vec;
   logic [N-1:0]  e_ack;

   always #(CLK_PERIOD / 2) clk = ~clk;

   intc_two_level #(.N(N), .VW(VW), .NMI_VEC(32'h1C), .BRK_VEC(32'h20), .SRC_BASE(32'h40))
   i_intc_two_level (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en), .lvl_i(lvl),
      .nmi_i(nmi), .brk_i(brk), .mask_i(mask), .boundary_i(bnd), .mode_i(mode),
      .irq_o(irq), .set_mask_o(set_mask), .vector_o(vector), .ack_o(ack),
      .nmi_ack_o(nmi_ack), .brk_ack_o(brk_ack)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model written from the requirements.
   task automatic predict();
      logic [N-1:0] p, pool;
      bit found;
      e_irq = 1'b0; e_nmi = 1'b0; e_brk = 1'b0; e_ack = '0; e_vec = '0;
      p = req & en;
      if (bnd && mode == 2'b00 && !prev_irq) begin
         if (nmi) begin
            e_irq = 1'b1; e_nmi = 1'b1; e_vec = NMI_V;
         end else if (brk) begin
            e_irq = 1'b1; e_brk = 1'b1; e_vec = BRK_V;
         end else if (!mask && p != '0) begin
            pool = ((p & lvl) != '0) ? (p & lvl) : p;
            found = 1'b0;
            for (int i = 0; i < N; i++) begin
               if (pool[i] && !found) begin
                  found = 1'b1;
                  e_irq = 1'b1;
                  e_ack[i] = 1'b1;
                  e_vec = SRC_V + VW'(4 * i);
               end
            end
         end
      end
   endtask

   task automatic step(input string tag, input logic [N-1:0] r, input logic [N-1:0] e,
                       input logic [N-1:0] l, input logic n, input logic b, input logic m,
                       input logic s, input logic [1:0] md);
      req = r; en = e; lvl = l; nmi = n; brk = b; mask = m; bnd = s; mode = md;
      predict();
      @(posedge clk);
      @(negedge clk);
      check({tag, " irq"}, 32'(irq), 32'(e_irq));
      check({tag, " set_mask R8"}, 32'(set_mask), 32'(e_irq));
      check({tag, " ack R9"}, 32'({ack, nmi_ack, brk_ack}), 32'({e_ack, e_nmi, e_brk}));
      if (e_irq) check({tag, " vector R7"}, 32'(vector), 32'(e_vec));
      prev_irq = e_irq;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      req = 8'hFF; en = 8'hFF; nmi = 1'b1; bnd = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 reset irq", 32'(irq), 0);
      check("R11 reset ack", 32'({ack, nmi_ack, brk_ack, set_mask}), 0);
      bnd = 1'b0; nmi = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after reset", 32'({irq, ack, nmi_ack, brk_ack}), 0);

      step("R2 no strobe",        8'hFF, 8'hFF, 8'h00, 1, 1, 0, 0, 2'b00);
      step("R5 level beats index", 8'h22, 8'hFF, 8'h20, 0, 0, 0, 1, 2'b00);
      step("R8 strobe in accept", 8'h22, 8'hFF, 8'h20, 0, 0, 0, 1, 2'b00);
      step("R6 lowest index",     8'h44, 8'hFF, 8'h00, 0, 0, 0, 1, 2'b00);
      step("idle",                8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 2'b00);
      step("R6 lowest index lvl1", 8'hC0, 8'hFF, 8'hC0, 0, 0, 0, 1, 2'b00);
      step("idle",                8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 2'b00);
      step("R4 mask holds",       8'h08, 8'hFF, 8'h08, 0, 0, 1, 1, 2'b00);
      step("R3 nmi under mask",   8'h08, 8'hFF, 8'h08, 1, 1, 1, 1, 2'b00);
      step("idle",                8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 2'b00);
      step("R3 brk under mask",   8'hFF, 8'hFF, 8'hFF, 0, 1, 1, 1, 2'b00);
      step("idle",                8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 2'b00);
      step("R3 brk over level1",  8'h01, 8'hFF, 8'h01, 0, 1, 0, 1, 2'b00);
      step("idle",                8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 2'b00);
      step("R1 disabled ignored", 8'h11, 8'h10, 8'h01, 0, 0, 0, 1, 2'b00);
      step("idle",                8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 2'b00);
      step("R1 all disabled",     8'hFF, 8'h00, 8'hFF, 0, 0, 0, 1, 2'b00);
      step("R10 mode 2",          8'hFF, 8'hFF, 8'h00, 1, 1, 0, 1, 2'b10);
      step("R10 mode 1",          8'h01, 8'hFF, 8'h00, 0, 0, 0, 1, 2'b01);
      step("R7 top source",       8'h80, 8'h80, 8'h00, 0, 0, 0, 1, 2'b00);

      for (int k = 0; k < 4000; k++) begin
         step("random R2 R3 R4 R5 R6",
              N'($urandom), N'($urandom), N'($urandom),
              ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
              ($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0),
              ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule